// File: doc/BRIEF.md
# Raster 3x3 Convolution Datapath

This block filters an image streamed in raster order, one 8-bit pixel per clock, with a 3x3 kernel and returns a 20-bit sum of products per clock. Two row delays of programmable length sit in series, so the newest pixel, the pixel one row back and the pixel two rows back arrive together. A three-row window of registers holds the latest three columns of those rows. Nine multipliers and an adder produce the result, which is registered two advancing clocks after the window captures a sample. The oldest row stream also leaves the block as an 8-bit cascade output, so several blocks can be chained.

A 16-bit cascade input has two uses. In additive mode it carries the partial sum of an upstream block, shifted left by a selectable amount and added to the result. In external-row mode it replaces the internal row delays with two external row streams. Pixels and coefficients each have their own signed/unsigned selector. The result can be rounded to its upper 16 or upper 8 bits. A hold input freezes the whole datapath one clock after it is sampled. A new-frame input clears the datapath and leaves the configuration ports alone. The kernel, row length and mode bits are static ports.

A small fill tracker marks when the output first holds a real result. It has four states: ST_EMPTY (nothing captured), ST_PRIME1 (one sample in the window), ST_PRIME2 (one sample in the multiplier stage) and ST_RUN (output valid). Each advancing clock moves the tracker ST_EMPTY to ST_PRIME1, ST_PRIME1 to ST_PRIME2 and ST_PRIME2 to ST_RUN, and it stays in ST_RUN. A held clock keeps the current state. Reset or new-frame returns it to ST_EMPTY.

Top module: `conv3x3_core`

## Requirements
- R1: `cas_out` equals the pixel captured 2r advancing clocks earlier, where r is `row_len` and `row_len`=0 means 1024. It is 0 until that many advancing clocks have passed since reset or new-frame.
- R2: `coef_in` byte k (bits 8k+7..8k, k=0..8) weights window position k. Positions 0..2 form the top row and take the stream delayed 2r. Positions 3..5 form the middle row and take the stream delayed r. Positions 6..8 form the bottom row and take the live pixel. Within each row the lowest position is the oldest column. With r=3 this gives c0*x[n-8] + c1*x[n-7] + ... + c8*x[n].
- R3: `pix_signed`=1 reads pixels as two's complement and 0 reads them as unsigned. `coef_signed` does the same for coefficients, on its own. The sum wraps modulo 2^20.
- R4: The result for the sample captured on one advancing clock appears on `dout` after the second advancing clock that follows. `dout_valid` rises with the first such result and stays high until reset or new-frame.
- R5: When `cas_mode`=0, `cas_in` is read as a 16-bit two's complement value captured with the pixel, sign-extended to 20 bits, shifted left by 0, 2, 4 or 8 for `cas_shift` codes 00, 01, 10 or 11, and added to the result.
- R6: When `cas_mode`=1, `cas_in[7:0]` feeds the middle window row and `cas_in[15:8]` feeds the top row, using the pixel format. Nothing is added and `cas_shift` has no effect.
- R7: `rnd_mode` 01 adds 8 and clears `dout[3:0]`. Code 10 adds 2048 and clears `dout[11:0]`. Codes 00 and 11 leave the sum unrounded.
- R8: When `hold` is high at a rising edge, the next rising edge changes no state. The pixel presented for that edge is dropped and every output stays constant.
- R9: While `frame_n` is low, `dout`, `dout_valid` and `cas_out` read 0. Processing then starts over as if from reset, with the configuration ports unchanged.
- R10: While `rst_n` is low, `dout`, `dout_valid` and `cas_out` are 0.
- R11: `dout_drive` is the inverse of `oe_n` and has no effect on processing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Asynchronous new-frame clear, active low |
| hold | input | 1 | Freeze request, takes effect one clock later |
| pix_in | input | 8 | Raster pixel |
| cas_in | input | 16 | Cascade partial sum or two external row pixels |
| coef_in | input | 72 | Nine 8-bit kernel weights, byte k for position k |
| row_len | input | 10 | Row length, 0 means 1024 |
| pix_signed | input | 1 | Pixel format select |
| coef_signed | input | 1 | Coefficient format select |
| cas_mode | input | 1 | 0 additive cascade, 1 external rows |
| cas_shift | input | 2 | Cascade left-shift code |
| rnd_mode | input | 2 | Output rounding code |
| oe_n | input | 1 | Output enable request, active low |
| dout | output | 20 | Registered convolution result |
| dout_valid | output | 1 | Result valid flag |
| dout_drive | output | 1 | Output enable flag |
| cas_out | output | 8 | Pixel delayed by two rows |

## Verification
The bench streams data through several kernels. It covers the 9-tap line case (r=3), odd and even row lengths, and the 1024 encoding of a zero length. Each case is compared against a model of the window built from the bench's own pixel history. Swapping the row feeds, or reversing the column order, moves the weights onto the wrong pixels and breaks every sum after the window fills. A wrong sign extension only shows once a pixel or weight has its top bit set, so the signed cases use bytes above 0x7F. A cascade shift applied to the wrong code changes only the additive cases. Hold pulses are spread through the stream; a design that applied hold on the same edge, or dropped the wrong pixel, slips out of step with the model for the rest of the run. The fill checks on `cas_out` after new-frame catch a delay that replays stale samples instead of zeros.

// File: rtl/conv3x3_pkg.sv
package conv3x3_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_PRIME1 = 2'd1,
        ST_PRIME2 = 2'd2,
        ST_RUN    = 2'd3
    } fill_state_e;

    localparam logic [1:0] RND_NONE = 2'b00;
    localparam logic [1:0] RND_HI16 = 2'b01;
    localparam logic [1:0] RND_HI8  = 2'b10;

    localparam logic [1:0] CSH_0 = 2'b00;
    localparam logic [1:0] CSH_2 = 2'b01;
    localparam logic [1:0] CSH_4 = 2'b10;
    localparam logic [1:0] CSH_8 = 2'b11;

    localparam int TAPS = 9;

endpackage

// File: rtl/conv_rowdelay.sv
module conv_rowdelay #(
    parameter int W     = 8,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          adv,
    input  logic [AW:0]   len,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] ptr;
    logic [AW:0]   fill;

    // Circular store: the slot under the pointer holds the sample written len advances ago.
    always_ff @(posedge clk) begin
        if (adv) begin
            mem[ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            ptr  <= '0;
            fill <= '0;
        end else if (adv) begin
            ptr <= ({1'b0, ptr} >= len - 1'b1) ? '0 : ptr + 1'b1;
            if (fill < len) begin
                fill <= fill + 1'b1;
            end
        end
    end

    // Until len samples have entered since a clear, the line reads as zeros.
    assign dout = (fill >= len) ? mem[ptr] : '0;

    assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!clr_n)
        fill <= len);
    assert_ptr_bound_R1: assert property (@(posedge clk) disable iff (!clr_n)
        {1'b0, ptr} < len);

endmodule

// File: rtl/conv_window.sv
module conv_window #(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  clr_n,
    input  logic                  adv,
    input  logic [2:0][W-1:0]     row_in,
    output logic [2:0][2:0][W-1:0] taps
);

    // taps[row][col]: col 2 newest, col 0 oldest; row 0 top (oldest line).
    for (genvar r = 0; r < 3; r++) begin : g_row
        logic [2:0][W-1:0] q;
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
                q <= '0;
            end else if (adv) begin
                q <= {row_in[r], q[2], q[1]};
            end
        end
        assign taps[r] = q;
    end

endmodule

// File: rtl/conv_mac.sv
module conv_mac
    import conv3x3_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int OUT_W = 20,
    localparam int PROD_W = 2 * PIX_W + 2,
    localparam int LSB16  = OUT_W - 16,
    localparam int LSB8   = OUT_W - 8
) (
    input  logic                        clk,
    input  logic                        clr_n,
    input  logic                        adv,
    input  logic [2:0][2:0][PIX_W-1:0]  taps,
    input  logic [TAPS-1:0][PIX_W-1:0]  coefs,
    input  logic                        pix_signed,
    input  logic                        coef_signed,
    input  logic [OUT_W-1:0]            addend,
    input  logic [1:0]                  rnd_mode,
    output logic [OUT_W-1:0]            result
);

    logic [TAPS-1:0][OUT_W-1:0] prod_q;
    logic [OUT_W-1:0]           add_q;
    logic [OUT_W-1:0]           sum;
    logic [OUT_W-1:0]           rounded;

    for (genvar k = 0; k < TAPS; k++) begin : g_mul
        logic signed [PIX_W:0]    a_x;
        logic signed [PIX_W:0]    c_x;
        logic signed [PROD_W-1:0] p;
        assign a_x = pix_signed ? $signed({taps[k/3][k%3][PIX_W-1], taps[k/3][k%3]})
                                : $signed({1'b0, taps[k/3][k%3]});
        assign c_x = coef_signed ? $signed({coefs[k][PIX_W-1], coefs[k]})
                                 : $signed({1'b0, coefs[k]});
        assign p = a_x * c_x;
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
                prod_q[k] <= '0;
            end else if (adv) begin
                prod_q[k] <= {{(OUT_W-PROD_W){p[PROD_W-1]}}, p};
            end
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            add_q <= '0;
        end else if (adv) begin
            add_q <= addend;
        end
    end

    always_comb begin
        sum = add_q;
        for (int k = 0; k < TAPS; k++) begin
            sum = sum + prod_q[k];
        end
    end

    always_comb begin
        unique case (rnd_mode)
            RND_HI16: begin
                rounded = sum + OUT_W'(1 << (LSB16 - 1));
                rounded[LSB16-1:0] = '0;
            end
            RND_HI8: begin
                rounded = sum + OUT_W'(1 << (LSB8 - 1));
                rounded[LSB8-1:0] = '0;
            end
            default: rounded = sum;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            result <= '0;
        end else if (adv) begin
            result <= rounded;
        end
    end

endmodule

// File: rtl/conv3x3_core.sv
module conv3x3_core
    import conv3x3_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int CAS_W   = 16,
    parameter int OUT_W   = 20,
    parameter int MAX_ROW = 1024,
    localparam int AW     = $clog2(MAX_ROW)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_n,
    input  logic                    hold,
    input  logic [PIX_W-1:0]        pix_in,
    input  logic [CAS_W-1:0]        cas_in,
    input  logic [TAPS*PIX_W-1:0]   coef_in,
    input  logic [AW-1:0]           row_len,
    input  logic                    pix_signed,
    input  logic                    coef_signed,
    input  logic                    cas_mode,
    input  logic [1:0]              cas_shift,
    input  logic [1:0]              rnd_mode,
    input  logic                    oe_n,
    output logic [OUT_W-1:0]        dout,
    output logic                    dout_valid,
    output logic                    dout_drive,
    output logic [PIX_W-1:0]        cas_out
);

    logic                         clr_n;
    logic                         hold_q;
    logic                         adv;
    logic [AW:0]                  eff_len;
    logic [PIX_W-1:0]             line1;
    logic [PIX_W-1:0]             line2;
    logic [2:0][PIX_W-1:0]        rows;
    logic [2:0][2:0][PIX_W-1:0]   taps;
    logic [TAPS-1:0][PIX_W-1:0]   coefs;
    logic [CAS_W-1:0]             cas_q;
    logic [OUT_W-1:0]             cas_ext;
    logic [OUT_W-1:0]             addend;
    fill_state_e                  state_q;
    fill_state_e                  state_d;

    assign clr_n   = rst_n & frame_n;
    assign eff_len = (row_len == '0) ? (AW+1)'(MAX_ROW) : {1'b0, row_len};
    assign coefs   = coef_in;

    // Hold is registered: it stops the edge after the one that samples it.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold;
        end
    end
    assign adv = ~hold_q;

    conv_rowdelay #(.W(PIX_W), .DEPTH(MAX_ROW)) u_line1 (
        .clk(clk), .clr_n(clr_n), .adv(adv), .len(eff_len),
        .din(pix_in), .dout(line1)
    );

    conv_rowdelay #(.W(PIX_W), .DEPTH(MAX_ROW)) u_line2 (
        .clk(clk), .clr_n(clr_n), .adv(adv), .len(eff_len),
        .din(line1), .dout(line2)
    );

    assign cas_out = line2;

    always_comb begin
        rows[2] = pix_in;
        if (cas_mode) begin
            rows[1] = cas_in[PIX_W-1:0];
            rows[0] = cas_in[2*PIX_W-1:PIX_W];
        end else begin
            rows[1] = line1;
            rows[0] = line2;
        end
    end

    conv_window #(.W(PIX_W)) u_window (
        .clk(clk), .clr_n(clr_n), .adv(adv), .row_in(rows), .taps(taps)
    );

    // Cascade word travels alongside the window sample it belongs to.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cas_q <= '0;
        end else if (adv) begin
            cas_q <= cas_in;
        end
    end

    assign cas_ext = {{(OUT_W-CAS_W){cas_q[CAS_W-1]}}, cas_q};

    always_comb begin
        if (cas_mode) begin
            addend = '0;
        end else begin
            unique case (cas_shift)
                CSH_0:   addend = cas_ext;
                CSH_2:   addend = cas_ext << 2;
                CSH_4:   addend = cas_ext << 4;
                CSH_8:   addend = cas_ext << 8;
                default: addend = cas_ext;
            endcase
        end
    end

    conv_mac #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_mac (
        .clk(clk), .clr_n(clr_n), .adv(adv), .taps(taps), .coefs(coefs),
        .pix_signed(pix_signed), .coef_signed(coef_signed),
        .addend(addend), .rnd_mode(rnd_mode), .result(dout)
    );

    // Fill tracker: state register
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                ST_EMPTY:  state_d = ST_PRIME1;
                ST_PRIME1: state_d = ST_PRIME2;
                ST_PRIME2: state_d = ST_RUN;
                ST_RUN:    state_d = ST_RUN;
                default:   state_d = ST_EMPTY;
            endcase
        end
    end

    // Fill tracker: outputs
    always_comb begin
        dout_valid = (state_q == ST_RUN);
        dout_drive = ~oe_n;
    end

    assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (!clr_n)
        hold_q |=> ($stable(dout) && $stable(dout_valid) && $stable(cas_out)));
    assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (!clr_n)
        dout_valid |=> dout_valid);
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!clr_n)
        !dout_valid |-> (dout == '0));

endmodule

// File: tb/conv3x3_core_tb_top.sv
`timescale 1ns/1ps
module conv3x3_core_tb_top;

    localparam real CLK_HALF = 2.5;
    localparam int  NSCEN    = 6;
    localparam int  HIST     = 4096;

    typedef struct packed {
        logic [71:0] coef;
        logic [9:0]  rlen;
        logic        ps;
        logic        cs;
        logic [1:0]  rnd;
        logic        mode;
        logic [1:0]  sh;
        logic        holds;
        logic [11:0] count;
    } scen_t;

    localparam scen_t SCEN [NSCEN] = '{
        '{72'h090807060504030201, 10'd3, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 12'd40},
        '{72'hFF02FE01807F03FD04, 10'd5, 1'b1, 1'b1, 2'd1, 1'b0, 2'd1, 1'b0, 12'd48},
        '{72'h8110F02205EE09C037, 10'd4, 1'b0, 1'b1, 2'd2, 1'b0, 2'd3, 1'b1, 12'd48},
        '{72'h11F203C455069708E9, 10'd6, 1'b1, 1'b0, 2'd3, 1'b1, 2'd1, 1'b1, 12'd48},
        '{72'h010203040506070809, 10'd3, 1'b1, 1'b1, 2'd0, 1'b0, 2'd2, 1'b1, 12'd40},
        '{72'h030102FF04FE010002, 10'd0, 1'b0, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 12'd2100}
    };

    logic        clk = 1'b0;
    logic        rst_n, frame_n, hold;
    logic [7:0]  pix_in;
    logic [15:0] cas_in;
    logic [71:0] coef_in;
    logic [9:0]  row_len;
    logic        pix_signed, coef_signed, cas_mode;
    logic [1:0]  cas_shift, rnd_mode;
    logic        oe_n;
    logic [19:0] dout;
    logic        dout_valid, dout_drive;
    logic [7:0]  cas_out;

    int n_checks = 0;
    int n_fail   = 0;
    int px [HIST];
    int cv [HIST];
    scen_t sc;
    int r_eff;

    always #(CLK_HALF) clk = ~clk;

    conv3x3_core dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .hold(hold),
        .pix_in(pix_in), .cas_in(cas_in), .coef_in(coef_in), .row_len(row_len),
        .pix_signed(pix_signed), .coef_signed(coef_signed), .cas_mode(cas_mode),
        .cas_shift(cas_shift), .rnd_mode(rnd_mode), .oe_n(oe_n),
        .dout(dout), .dout_valid(dout_valid), .dout_drive(dout_drive),
        .cas_out(cas_out)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    function automatic string tag_of(int s);
        case (s)
            0:       return "R2 fir";
            1:       return "R3 R5 R7 signed";
            2:       return "R3 R5 R7 R8 mixed";
            3:       return "R6 R7 R8 external rows";
            4:       return "R2 R5 R8 reversed";
            default: return "R1 R7 long row";
        endcase
    endfunction

    function automatic int px_at(int idx);
        return (idx < 0) ? 0 : px[idx];
    endfunction

    function automatic int exp_dout(int j);
        int acc;
        int s;
        acc = 0;
        for (int row = 0; row < 3; row++) begin
            for (int col = 0; col < 3; col++) begin
                int idx;
                int v;
                int c;
                idx = j - (2 - col);
                if (row == 2) v = px_at(idx);
                else if (sc.mode) v = (idx < 0) ? 0 :
                                      ((row == 1) ? (cv[idx] & 255) : ((cv[idx] >> 8) & 255));
                else v = px_at(idx - (2 - row) * r_eff);
                if (sc.ps && v >= 128) v = v - 256;
                c = int'(sc.coef[8*(row*3+col) +: 8]);
                if (sc.cs && c >= 128) c = c - 256;
                acc = acc + v * c;
            end
        end
        if (!sc.mode) begin
            int cc;
            int sh;
            cc = cv[j];
            if (cc >= 32768) cc = cc - 65536;
            sh = (sc.sh == 2'd0) ? 0 : (sc.sh == 2'd1) ? 2 : (sc.sh == 2'd2) ? 4 : 8;
            acc = acc + (cc <<< sh);
        end
        s = acc & 'hFFFFF;
        if (sc.rnd == 2'd1) s = (s + 8) & 'hFFFF0;
        else if (sc.rnd == 2'd2) s = (s + 2048) & 'hFF000;
        return s;
    endfunction

    task automatic run_scen(input int s);
        int a;
        int cyc;
        logic hold_prev;
        logic hold_now;
        string tg;
        sc = SCEN[s];
        tg = tag_of(s);
        r_eff = (sc.rlen == 10'd0) ? 1024 : int'(sc.rlen);
        @(negedge clk);
        frame_n = 1'b0;
        hold = 1'b0;
        coef_in = sc.coef; row_len = sc.rlen; pix_signed = sc.ps;
        coef_signed = sc.cs; rnd_mode = sc.rnd; cas_mode = sc.mode; cas_shift = sc.sh;
        pix_in = '0; cas_in = '0;
        @(negedge clk);
        chk("R9 frame dout", int'(dout), 0);
        chk("R9 frame valid", int'(dout_valid), 0);
        chk("R9 frame cas_out", int'(cas_out), 0);
        frame_n = 1'b1;
        a = 0; cyc = 0; hold_prev = 1'b0;
        while (a < int'(sc.count)) begin
            chk("R4 valid", int'(dout_valid), (a >= 3) ? 1 : 0);
            chk(tg, int'(dout), (a >= 3) ? exp_dout(a - 3) : 0);
            chk("R1 cas_out", int'(cas_out), (a - 2*r_eff >= 0) ? px[a - 2*r_eff] : 0);
            hold_now = sc.holds && (cyc % 7 == 3);
            hold = hold_now;
            pix_in = 8'((a*29 + s*53 + cyc*7 + (a >> 2)) & 255);
            cas_in = 16'((a*2311 + s*977 + cyc*5 + 13) & 16'hFFFF);
            @(posedge clk);
            if (!hold_prev) begin
                px[a] = int'(pix_in);
                cv[a] = int'(cas_in);
                a++;
            end
            hold_prev = hold_now;
            cyc++;
            @(negedge clk);
        end
        hold = 1'b0;
    endtask

    initial begin
        #(CLK_HALF * 2.0 * 100000.0);
        n_fail++;
        $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; frame_n = 1'b1; hold = 1'b0; pix_in = '0; cas_in = '0;
        coef_in = '0; row_len = '0; pix_signed = 1'b0; coef_signed = 1'b0;
        cas_mode = 1'b0; cas_shift = '0; rnd_mode = '0; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 reset dout", int'(dout), 0);
        chk("R10 reset valid", int'(dout_valid), 0);
        chk("R10 reset cas_out", int'(cas_out), 0);
        chk("R11 drive off", int'(dout_drive), 0);
        oe_n = 1'b0;
        #1;
        chk("R11 drive on", int'(dout_drive), 1);
        rst_n = 1'b1;
        for (int s = 0; s < NSCEN; s++) begin
            run_scen(s);
        end
        oe_n = 1'b1;
        #1;
        chk("R11 drive off after run", int'(dout_drive), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule